// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block sits between on-chip logic and a small serial EEPROM holding 128 bytes. The client hands it one request at a time over a valid/ready port: either a one-byte read or a write of one or more bytes starting at a 7-bit address. The block frames each instruction as a start bit, a two-bit opcode and the address. It clocks the frame out on the serial lines and returns the read byte or a write status code on a one-cycle result strobe.

Every write request is wrapped. A write-unlock instruction comes first, then one write frame per byte at rising addresses, then a write-lock instruction. After each byte the block drops chip select, raises it again and watches the device's data line. The line must first go low (programming in progress) and then high (programming finished). If the line never goes low, or never returns high within a cycle budget, a fault code is reported and the remaining bytes of the request are skipped.

The serial clock is the system clock divided by a parameter. Data-out changes while the serial clock falls and data-in is captured as it rises. The client supplies successive write bytes on one data port and advances it on each take strobe.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Every instruction is sent most significant bit first as a start bit of 1, a two-bit opcode, then address bits A6 down to A0, with chip select high for the whole frame. Opcode 10 reads and opcode 01 writes.
- R2: A read sends a read frame and keeps clocking 8 more serial clocks. It returns the 8 bits captured on those clocks, first bit as bit 7, on `done_rdata` with `done_status` 0.
- R3: A write frame is followed in the same chip-select window by the 8 data bits, bit 7 first.
- R4: A write request begins with opcode 00 and address 1100000 (unlock) and ends with opcode 00 and address 0000000 (lock). Every instruction has its own chip-select window.
- R5: A write of `req_len`+1 bytes writes consecutive addresses from `req_addr`, wrapping from 127 to 0. Each write frame uses the byte on `req_wdata` in the cycle `wdata_take` rises.
- R6: After each write frame, chip select drops and then rises with no serial clock. Data-in is sampled every POLL_IVL cycles, and a low sample followed by a high one ends that byte with status 0.
- R7: If the first two samples after chip select rises are both high, the byte ends with status 1.
- R8: If no ready sample follows busy within POLL_LIMIT cycles of raising chip select, the byte ends with status 2.
- R9: A nonzero status skips the remaining bytes, still sends the lock instruction, and is the reported status.
- R10: The serial clock stays low while chip select is low. Each serial clock half-period lasts HALF_DIV system cycles, and data-out holds steady while the serial clock is high.
- R11: Chip select stays low for at least 4*HALF_DIV cycles (two serial periods) between windows.
- R12: `req_ready` is high only when idle and falls after an accepted request. `done_valid` is a single-cycle pulse, and the block is ready again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_addr | input | 7 | Start address |
| req_len | input | 7 | Write byte count minus one |
| req_wdata | input | 8 | Current write byte |
| wdata_take | output | 1 | Current write byte consumed; present the next one |
| done_valid | output | 1 | Result strobe |
| done_status | output | 2 | 0 ok, 1 busy never seen, 2 ready timeout |
| done_rdata | output | 8 | Byte returned by a read |
| ee_cs | output | 1 | Chip select, active high |
| ee_sclk | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to the device |
| ee_miso | input | 1 | Serial data and ready/busy from the device |

## Verification
The bench builds the block with HALF_DIV = 2, POLL_IVL = 4 and POLL_LIMIT = 200. A whole wrapped write therefore takes a few hundred cycles instead of milliseconds. A device model whose busy time is set to 30, 0 or 1000 cycles can then drive the normal, never-busy and timeout endings in one short run. The two-cycle half period is also the smallest that lets the sampled device model answer a read one serial edge late and still be captured.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_CTRL  = 2'b00;

   localparam logic [1:0] STAT_OK     = 2'd0;
   localparam logic [1:0] STAT_NOBUSY = 2'd1;
   localparam logic [1:0] STAT_TMO    = 2'd2;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SEND,
      S_GAP,
      S_POLL,
      S_DONE
   } mw_state_e;

   typedef enum logic [1:0] {
      N_WRITE,
      N_POLL,
      N_LOCK,
      N_FINISH
   } mw_next_e;

endpackage

// File: rtl/mw_bit_engine.sv
module mw_bit_engine #(
   parameter int FRAME_W  = 18,
   parameter int DATA_W   = 8,
   parameter int HALF_DIV = 63
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [FRAME_W-1:0]           word,
   input  logic [$clog2(FRAME_W+1)-1:0] nbits,
   input  logic                         miso,
   output logic                         sclk,
   output logic                         mosi,
   output logic                         done,
   output logic [DATA_W-1:0]            rx
);
   localparam int NB_W = $clog2(FRAME_W+1);

   logic              active;
   logic              half_end;
   logic [FRAME_W-1:0] sh;
   logic [NB_W-1:0]   cnt;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign half_end = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] div;
         assign half_end = (div == DW'(HALF_DIV-1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 div <= '0;
            else if (start || half_end) div <= '0;
            else if (active)            div <= div + 1'b1;
         end
      end
   endgenerate

   assign done = active && half_end && sclk && (cnt == NB_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk   <= 1'b0;
         mosi   <= 1'b0;
         sh     <= '0;
         cnt    <= '0;
         rx     <= '0;
      end else if (start) begin
         active <= 1'b1;
         sclk   <= 1'b0;
         mosi   <= word[FRAME_W-1];
         sh     <= word;
         cnt    <= nbits;
      end else if (active && half_end) begin
         if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[DATA_W-2:0], miso};
         end else begin
            sclk <= 1'b0;
            sh   <= sh << 1;
            cnt  <= cnt - 1'b1;
            if (cnt == NB_W'(1)) begin
               active <= 1'b0;
               mosi   <= 1'b0;
            end else begin
               mosi <= sh[FRAME_W-2];
            end
         end
      end
   end
endmodule

// File: rtl/mw_poll_judge.sv
module mw_poll_judge #(
   parameter int POLL_IVL   = 125,
   parameter int POLL_LIMIT = 1250000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       run,
   input  logic       miso,
   output logic       fin,
   output logic [1:0] code
);
   import mw_eeprom_pkg::*;
   localparam int TW = $clog2(POLL_LIMIT+1);

   logic [TW-1:0] tot;
   logic          seen_low;
   logic          first;
   logic          smp;
   logic          ok, nob, tmo;

   generate
      if (POLL_IVL == 1) begin : g_every
         assign smp = run;
      end else begin : g_ivl
         localparam int IW = $clog2(POLL_IVL);
         logic [IW-1:0] ivl;
         assign smp = run && (ivl == IW'(POLL_IVL-1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ivl <= '0;
            else if (clear)      ivl <= '0;
            else if (smp)        ivl <= '0;
            else if (run)        ivl <= ivl + 1'b1;
         end
      end
   endgenerate

   assign ok   = smp && miso && seen_low;
   assign nob  = smp && miso && !seen_low && first;
   assign tmo  = run && (tot == TW'(POLL_LIMIT-1)) && !ok && !nob;
   assign fin  = ok || nob || tmo;
   assign code = nob ? STAT_NOBUSY : (tmo ? STAT_TMO : STAT_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot      <= '0;
         seen_low <= 1'b0;
         first    <= 1'b0;
      end else if (clear) begin
         tot      <= '0;
         seen_low <= 1'b0;
         first    <= 1'b0;
      end else if (run) begin
         tot <= tot + 1'b1;
         if (smp) first <= 1'b1;
         if (smp && !miso) seen_low <= 1'b1;
      end
   end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
   import mw_eeprom_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int HALF_DIV   = 63,
   parameter int POLL_IVL   = 125,
   parameter int POLL_LIMIT = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              wdata_take,
   output logic              done_valid,
   output logic [1:0]        done_status,
   output logic [DATA_W-1:0] done_rdata,
   output logic              ee_cs,
   output logic              ee_sclk,
   output logic              ee_mosi,
   input  logic              ee_miso
);
   localparam int HDR_W   = 3 + ADDR_W;
   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int NB_W    = $clog2(FRAME_W+1);
   localparam int GAP_CYC = 4 * HALF_DIV;
   localparam int GW      = $clog2(GAP_CYC+1);
   localparam logic [ADDR_W-1:0] ADR_UNLOCK = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] ADR_LOCK   = '0;

   if (ADDR_W < 2)                  begin : g_bad_aw  $error("ADDR_W must be at least 2"); end
   if (DATA_W < 2)                  begin : g_bad_dw  $error("DATA_W must be at least 2"); end
   if (HALF_DIV < 1)                begin : g_bad_div $error("HALF_DIV must be at least 1"); end
   if (POLL_IVL < 1)                begin : g_bad_ivl $error("POLL_IVL must be at least 1"); end
   if (POLL_LIMIT <= 2*POLL_IVL)    begin : g_bad_lim $error("POLL_LIMIT must exceed two poll intervals"); end

   mw_state_e         state;
   mw_next_e          nxt;
   logic [ADDR_W-1:0] addr_q, left_q;
   logic              is_wr;
   logic [1:0]        stat_q;
   logic [DATA_W-1:0] rdata_q;
   logic [GW-1:0]     gap_q;
   logic              take_q;
   logic              gap_done;

   logic               eng_start, eng_done;
   logic [FRAME_W-1:0] eng_word;
   logic [NB_W-1:0]    eng_nb;
   logic [DATA_W-1:0]  eng_rx;

   logic       pj_clear, pj_fin;
   logic [1:0] pj_code;

   assign gap_done = (gap_q == GW'(GAP_CYC-1));

   always_comb begin
      eng_start = 1'b0;
      eng_word  = '0;
      eng_nb    = '0;
      if (state == S_IDLE && req_valid) begin
         eng_start = 1'b1;
         if (req_write) begin
            eng_word = {1'b1, OPC_CTRL, ADR_UNLOCK, {DATA_W{1'b0}}};
            eng_nb   = NB_W'(HDR_W);
         end else begin
            eng_word = {1'b1, OPC_READ, req_addr, {DATA_W{1'b0}}};
            eng_nb   = NB_W'(FRAME_W);
         end
      end else if (state == S_GAP && gap_done) begin
         if (nxt == N_WRITE) begin
            eng_start = 1'b1;
            eng_word  = {1'b1, OPC_WRITE, addr_q, req_wdata};
            eng_nb    = NB_W'(FRAME_W);
         end else if (nxt == N_LOCK) begin
            eng_start = 1'b1;
            eng_word  = {1'b1, OPC_CTRL, ADR_LOCK, {DATA_W{1'b0}}};
            eng_nb    = NB_W'(HDR_W);
         end
      end
   end

   assign pj_clear = (state == S_GAP) && gap_done && (nxt == N_POLL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         nxt     <= N_FINISH;
         addr_q  <= '0;
         left_q  <= '0;
         is_wr   <= 1'b0;
         stat_q  <= STAT_OK;
         rdata_q <= '0;
         gap_q   <= '0;
         take_q  <= 1'b0;
      end else begin
         take_q <= 1'b0;
         unique case (state)
            S_IDLE: if (req_valid) begin
               addr_q <= req_addr;
               left_q <= req_len;
               is_wr  <= req_write;
               stat_q <= STAT_OK;
               nxt    <= req_write ? N_WRITE : N_FINISH;
               state  <= S_SEND;
            end
            S_SEND: if (eng_done) begin
               if (!is_wr) rdata_q <= eng_rx;
               gap_q <= '0;
               state <= S_GAP;
            end
            S_GAP: begin
               gap_q <= gap_q + 1'b1;
               if (gap_done) begin
                  unique case (nxt)
                     N_WRITE: begin
                        take_q <= 1'b1;
                        nxt    <= N_POLL;
                        state  <= S_SEND;
                     end
                     N_POLL:   state <= S_POLL;
                     N_LOCK: begin
                        nxt   <= N_FINISH;
                        state <= S_SEND;
                     end
                     N_FINISH: state <= S_DONE;
                  endcase
               end
            end
            S_POLL: if (pj_fin) begin
               gap_q <= '0;
               state <= S_GAP;
               if (pj_code != STAT_OK || left_q == '0) begin
                  stat_q <= pj_code;
                  nxt    <= N_LOCK;
               end else begin
                  left_q <= left_q - 1'b1;
                  addr_q <= addr_q + 1'b1;
                  nxt    <= N_WRITE;
               end
            end
            S_DONE: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   mw_bit_engine #(
      .FRAME_W (FRAME_W),
      .DATA_W  (DATA_W),
      .HALF_DIV(HALF_DIV)
   ) u_eng (
      .clk  (clk),
      .rst_n(rst_n),
      .start(eng_start),
      .word (eng_word),
      .nbits(eng_nb),
      .miso (ee_miso),
      .sclk (ee_sclk),
      .mosi (ee_mosi),
      .done (eng_done),
      .rx   (eng_rx)
   );

   mw_poll_judge #(
      .POLL_IVL  (POLL_IVL),
      .POLL_LIMIT(POLL_LIMIT)
   ) u_poll (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(pj_clear),
      .run  (state == S_POLL),
      .miso (ee_miso),
      .fin  (pj_fin),
      .code (pj_code)
   );

   assign req_ready   = (state == S_IDLE);
   assign done_valid  = (state == S_DONE);
   assign done_status = stat_q;
   assign done_rdata  = rdata_q;
   assign wdata_take  = take_q;
   assign ee_cs       = (state == S_SEND) || (state == S_POLL);
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk #(
   parameter int GAP_CYC = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       req_write,
   input logic       wdata_take,
   input logic       done_valid,
   input logic [1:0] done_status,
   input logic       ee_cs,
   input logic       ee_sclk,
   input logic       ee_mosi
);
   localparam int LW = $clog2(GAP_CYC+1);

   logic [LW-1:0] low_cnt;
   logic          last_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        low_cnt <= LW'(GAP_CYC);
      else if (ee_cs)                    low_cnt <= '0;
      else if (low_cnt < LW'(GAP_CYC))   low_cnt <= low_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     last_wr <= 1'b0;
      else if (req_valid && req_ready) last_wr <= req_write;
   end

   p_cs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> (low_cnt >= LW'(GAP_CYC)));

   p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs |-> !ee_sclk);

   p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_cs && ee_sclk) |-> $stable(ee_mosi));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   p_busy_no_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_read_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !last_wr) |-> (done_status == 2'd0));

   p_take_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_take |-> (ee_cs && !ee_sclk && last_wr));

   p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_status != 2'd3));
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.GAP_CYC(4*HALF_DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .wdata_take (wdata_take),
   .done_valid (done_valid),
   .done_status(done_status),
   .ee_cs      (ee_cs),
   .ee_sclk    (ee_sclk),
   .ee_mosi    (ee_mosi)
);

// File: tb/mw_eeprom_ctrl_tb.sv
module mw_eeprom_ctrl_tb;
   localparam int HALF = 2;
   localparam int IVL  = 4;
   localparam int LIM  = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_write = 1'b0;
   logic [6:0] req_addr = '0;
   logic [6:0] req_len = '0;
   logic [7:0] req_wdata;
   logic       wdata_take, done_valid;
   logic [1:0] done_status;
   logic [7:0] done_rdata;
   logic       ee_cs, ee_sclk, ee_mosi, ee_miso;

   always #4 clk = ~clk;

   mw_eeprom_ctrl #(.HALF_DIV(HALF), .POLL_IVL(IVL), .POLL_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .wdata_take(wdata_take), .done_valid(done_valid),
      .done_status(done_status), .done_rdata(done_rdata), .ee_cs(ee_cs),
      .ee_sclk(ee_sclk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
   );

   // scoreboard queues: frames {long, hdr[9:0], data[7:0]}, results {rd_flag, status, rdata}
   logic [18:0] exp_ins[$];
   logic [10:0] exp_res[$];
   int chk_m = 0, bad_m = 0, chk_i = 0, bad_i = 0, chk_r = 0, bad_r = 0;
   int busy_cyc = 30;

   logic [7:0] wbuf[0:7];
   int wptr = 0;
   assign req_wdata = wbuf[wptr];

   // ---------------- device model ----------------
   logic [7:0]  mem[0:127];
   logic [17:0] sh;
   int          nb, rd_idx, busy_cnt;
   logic        cs_p, sclk_p, reading, rd_bit, en;
   logic [6:0]  rd_a;

   assign ee_miso = ee_cs ? (reading ? rd_bit : (busy_cnt == 0)) : 1'b1;

   always @(posedge clk) begin
      logic [9:0]  h;
      logic [18:0] obs, e;
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'h5A;
         cs_p <= 0; sclk_p <= 0; nb <= 0; reading <= 0; rd_bit <= 0;
         en <= 0; busy_cnt <= 0; rd_idx <= 0; sh <= '0; rd_a <= '0;
      end else begin
         cs_p <= ee_cs; sclk_p <= ee_sclk;
         if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
         if (ee_cs && !cs_p) begin nb <= 0; reading <= 0; end
         if (ee_cs && ee_sclk && !sclk_p) begin
            sh <= {sh[16:0], ee_mosi};
            nb <= nb + 1;
            h = {sh[8:0], ee_mosi};
            if (nb == 9 && h[8:7] == 2'b10) begin
               reading <= 1; rd_idx <= 0; rd_a <= h[6:0];
            end
         end
         if (ee_cs && !ee_sclk && sclk_p && reading && rd_idx < 8) begin
            rd_bit <= mem[rd_a][7-rd_idx];
            rd_idx <= rd_idx + 1;
         end
         if (!ee_cs && cs_p && nb > 0) begin
            obs = (nb == 18) ? {1'b1, sh} : {1'b0, sh[9:0], 8'h00};
            if (nb == 10 && sh[8:7] == 2'b00) begin
               if (sh[6:5] == 2'b11) en <= 1;
               if (sh[6:5] == 2'b00) en <= 0;
            end
            if (nb == 18 && sh[16:15] == 2'b01 && en) begin
               mem[sh[14:8]] <= sh[7:0];
               busy_cnt <= busy_cyc;
            end
            chk_i++;
            if (exp_ins.size() == 0) begin
               bad_i++;
               $display("FAIL R1 unexpected frame got %h expected none", obs);
            end else begin
               e = exp_ins.pop_front();
               if (obs[18:8] != e[18:8] || (e[17:16] == 2'b01 && obs[7:0] != e[7:0])) begin
                  bad_i++;
                  $display("FAIL R1/R3/R4 frame got %h expected %h", obs, e);
               end
            end
         end
      end
   end

   // ---------------- result monitor ----------------
   always @(negedge clk) begin
      logic [10:0] e;
      if (rst_n && done_valid) begin
         chk_r++;
         if (exp_res.size() == 0) begin
            bad_r++;
            $display("FAIL R12 unexpected result st=%0d rd=%h expected none", done_status, done_rdata);
         end else begin
            e = exp_res.pop_front();
            if (done_status != e[9:8] || (e[10] && done_rdata != e[7:0])) begin
               bad_r++;
               $display("FAIL R2/R6/R7/R8/R9 result st=%0d rd=%h expected st=%0d rd=%h",
                        done_status, done_rdata, e[9:8], e[7:0]);
            end
         end
      end
   end

   // ---------------- serial timing trackers ----------------
   int hi_run = 0, hi_min = 1000, hi_max = 0, lo_run = 0, lo_min = 1000;
   logic cs_seen = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (ee_sclk) hi_run++;
         else if (hi_run > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
         end
         if (!ee_cs) lo_run++;
         else begin
            if (cs_seen && lo_run > 0 && lo_run < lo_min) lo_min = lo_run;
            if (lo_run > 0) cs_seen = 1;
            lo_run = 0;
         end
      end
   end

   // ---------------- driver ----------------
   task automatic run_req(input bit wr, input logic [6:0] a, input int n,
                          input int n_wr, input logic [1:0] st, input logic [7:0] rd);
      if (wr) begin
         exp_ins.push_back({1'b0, 1'b1, 2'b00, 7'b1100000, 8'h00});
         for (int i = 0; i < n_wr; i++)
            exp_ins.push_back({1'b1, 1'b1, 2'b01, 7'(a + 7'(i)), wbuf[i]});
         exp_ins.push_back({1'b0, 1'b1, 2'b00, 7'b0000000, 8'h00});
      end else begin
         exp_ins.push_back({1'b1, 1'b1, 2'b10, a, 8'h00});
      end
      exp_res.push_back({~wr, st, rd});
      wptr = 0;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_len = 7'(n - 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      chk_m++;
      if (req_ready) begin bad_m++; $display("FAIL R12 ready after accept got 1 expected 0"); end
      forever begin
         if (wdata_take) wptr++;
         if (done_valid) break;
         @(negedge clk);
      end
      @(negedge clk);
      chk_m++;
      if (!req_ready || done_valid) begin
         bad_m++;
         $display("FAIL R12 after result ready=%0d done=%0d expected 1 0", req_ready, done_valid);
      end
      chk_m++;
      if (wr && wptr != n_wr) begin
         bad_m++;
         $display("FAIL R5 take pulses got %0d expected %0d", wptr, n_wr);
      end
   endtask

   task automatic tests;
      for (int i = 0; i < 8; i++) wbuf[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk_m++;
      if (!req_ready || ee_cs || ee_sclk || done_valid) begin
         bad_m++;
         $display("FAIL R12 reset state rdy=%0d cs=%0d sclk=%0d done=%0d expected 1 0 0 0",
                  req_ready, ee_cs, ee_sclk, done_valid);
      end
      rst_n = 1;
      repeat (2) @(negedge clk);
      run_req(0, 7'd5, 1, 0, 2'd0, 8'h5F);                // R2
      run_req(0, 7'd127, 1, 0, 2'd0, 8'h25);              // R2 top address
      wbuf[0] = 8'hA5;
      run_req(1, 7'd10, 1, 1, 2'd0, 8'h00);               // R3 R4 R6
      run_req(0, 7'd10, 1, 0, 2'd0, 8'hA5);
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      run_req(1, 7'd126, 3, 3, 2'd0, 8'h00);              // R5 wrap 127 -> 0
      run_req(0, 7'd0, 1, 0, 2'd0, 8'h33);
      run_req(0, 7'd127, 1, 0, 2'd0, 8'h22);
      busy_cyc = 0;
      wbuf[0] = 8'h77;
      run_req(1, 7'd20, 1, 1, 2'd1, 8'h00);               // R7
      busy_cyc = 1000;
      wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
      run_req(1, 7'd30, 3, 1, 2'd2, 8'h00);               // R8 R9
      run_req(0, 7'd31, 1, 0, 2'd0, 8'h45);               // R9 skipped byte untouched
      run_req(0, 7'd30, 1, 0, 2'd0, 8'h44);
      repeat (1100) @(negedge clk);
      busy_cyc = 30;
      wbuf[0] = 8'hC3;
      run_req(1, 7'd40, 1, 1, 2'd0, 8'h00);               // R6 recovery
      run_req(0, 7'd40, 1, 0, 2'd0, 8'hC3);
      repeat (20) @(negedge clk);
      chk_m++;
      if (hi_min != HALF || hi_max != HALF) begin
         bad_m++;
         $display("FAIL R10 sclk high run min=%0d max=%0d expected %0d", hi_min, hi_max, HALF);
      end
      chk_m++;
      if (lo_min < 4*HALF) begin
         bad_m++;
         $display("FAIL R11 cs low gap got %0d expected >= %0d", lo_min, 4*HALF);
      end
      chk_m++;
      if (exp_ins.size() != 0 || exp_res.size() != 0) begin
         bad_m++;
         $display("FAIL R4 leftover expectations frames=%0d results=%0d expected 0 0",
                  exp_ins.size(), exp_res.size());
      end
   endtask

   initial begin
      bit wd;
      wd = 0;
      fork
         tests();
         begin
            repeat (150000) @(posedge clk);
            wd = 1;
         end
      join_any
      disable fork;
      if (wd) begin
         chk_m++; bad_m++;
         $display("FAIL R12 watchdog expired got hang expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", chk_m + chk_i + chk_r, bad_m + bad_i + bad_r);
      $finish;
   end
endmodule